// File: doc/BRIEF.md
# Configurable Register Macrocell

This block is the output stage of one programmable logic cell. A sum-of-products signal enters it, and it holds a single storage bit. Static configuration inputs decide whether that bit loads the sum (D behaviour) or flips when the sum is 1 (T behaviour). The same inputs pick which of four clocks drives the bit and which edge of that clock is used. Clock 0 always comes from a pin. Clocks 1 to 3 can each come from a pin or from a logic equation.

One of two low-numbered control terms can force the bit high or low asynchronously, or that feature can be switched off. The output driver has an enable chosen from four other control terms, or the enable can be fixed on or fixed off. An active-low global tri-state input overrides the chosen enable. A bypass setting sends the sum straight to the output instead of the stored bit.

Two feedback taps are provided. The cell tap shows the value presented to the output buffer. The pad tap shows what is on the pin: the driven value while the buffer is enabled, and the external pad value while it is not.

Top module: `mcell_stage`

## Requirements
- R1: When `cfg_t_mode`=0, each active edge of the selected clock loads `sop_in` into the register.
- R2: When `cfg_t_mode`=1, each active edge inverts the register if `sop_in`=1 and leaves it unchanged if `sop_in`=0.
- R3: `cfg_clk_sel` picks clock 0..3. With `cfg_clk_inv`=0 the rising edge of that clock is active, and with `cfg_clk_inv`=1 the falling edge is active. Edges of clocks that are not selected do not change the register.
- R4: Clock 0 is always `ext_clk[0]`. For k=1..3, clock k is `eqn_clk[k-1]` when `cfg_clk_src[k-1]`=1, and `ext_clk[k]` otherwise. The source that is not chosen has no effect.
- R5: `cfg_init_ct` selects `ctrl_term[0]` (0) or `ctrl_term[1]` (1). `cfg_init_mode` is 1 for preset or 2 for clear; 0 and 3 disable the feature. While the selected term is 1 in preset or clear mode, the register is forced to 1 or 0 at once, without waiting for a clock edge, and clock edges cannot change it. A term that is not selected has no effect.
- R6: While `rst_n`=0 the register is 0, whatever the clocks and the initialisation settings.
- R7: `cfg_oe_sel` values 0..3 take the local enable from `ctrl_term[2..5]`. Value 4 enables the output always, and values 5..7 disable it.
- R8: While `gts_n`=0, `pad_oe` is 0 whatever the local enable.
- R9: With `cfg_bypass`=1, `pad_out` and `mc_fb` follow `sop_in` combinationally. With `cfg_bypass`=0 they show the register. Bypass leaves the register's contents untouched.
- R10: `pin_fb` equals `pad_out` when `pad_oe`=1 and equals `pad_in` when `pad_oe`=0. `mc_fb` does not depend on the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_clk | input | 4 | Clocks arriving from pins |
| eqn_clk | input | 3 | Clocks generated by logic equations, for clocks 1..3 |
| sop_in | input | 1 | Sum-of-products data input |
| ctrl_term | input | 6 | Control terms: [1:0] for initialisation, [5:2] for output enable |
| gts_n | input | 1 | Global tri-state, active low |
| pad_in | input | 1 | Value present on the external pin |
| cfg_t_mode | input | 1 | 1 selects T behaviour, 0 selects D behaviour |
| cfg_clk_sel | input | 2 | Index of the clock that drives the register |
| cfg_clk_inv | input | 1 | 1 makes the falling edge active |
| cfg_clk_src | input | 3 | Per clock 1..3: 1 takes the equation clock |
| cfg_init_mode | input | 2 | 0/3 off, 1 preset, 2 clear |
| cfg_init_ct | input | 1 | Control term used for initialisation |
| cfg_oe_sel | input | 3 | Output enable source |
| cfg_bypass | input | 1 | 1 drives the output from `sop_in` directly |
| pad_out | output | 1 | Value presented to the output buffer |
| pad_oe | output | 1 | Output buffer enable |
| mc_fb | output | 1 | Feedback tapped before the buffer |
| pin_fb | output | 1 | Feedback tapped after the buffer |

## Verification
A stored bit that is wrong appears on `pad_out` and `mc_fb` at the first sample after the active edge that produced it. In T behaviour the error then persists, because every later toggle starts from the wrong value. An initialisation path that does not take effect shows up within one time step of the control term changing, well before any clock edge. A bad clock-select or polarity path shows up as a capture on the wrong edge, which the bench detects by sampling between the two edges of each period. Faults in the enable and pad-tap logic are purely combinational and are visible as soon as their inputs settle.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    INIT_OFF     = 2'd0,
    INIT_PRESET  = 2'd1,
    INIT_CLEAR   = 2'd2,
    INIT_OFF_ALT = 2'd3
  } init_mode_e;

  // Next register value for D (t_mode=0) or T (t_mode=1) behaviour.
  function automatic logic ff_next(input logic cur, input logic din, input logic t_mode);
    return t_mode ? (cur ^ din) : din;
  endfunction

  // Value seen on the pad side of the output buffer.
  function automatic logic pad_view(input logic drive, input logic oe, input logic pad);
    return oe ? drive : pad;
  endfunction

endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick #(
  parameter int NUM_CLK = 4,
  localparam int SEL_W = $clog2(NUM_CLK)
) (
  input  logic [NUM_CLK-1:0] ext_clk,
  input  logic [NUM_CLK-2:0] eqn_clk,
  input  logic [NUM_CLK-2:0] src_eqn,
  input  logic [SEL_W-1:0]   sel,
  input  logic               inv,
  output logic               cell_clk
);

  logic [NUM_CLK-1:0] cand;

  // Clock 0 has no equation source; the others choose per clock.
  assign cand[0] = ext_clk[0];
  for (genvar gi = 1; gi < NUM_CLK; gi++) begin : g_src
    assign cand[gi] = src_eqn[gi-1] ? eqn_clk[gi-1] : ext_clk[gi];
  end

  assign cell_clk = cand[sel] ^ inv;

endmodule

// File: rtl/mcell_init_ctl.sv
module mcell_init_ctl
  import mcell_pkg::*;
#(
  parameter int NUM_INIT_CT = 2,
  localparam int SEL_W = $clog2(NUM_INIT_CT)
) (
  input  logic [NUM_INIT_CT-1:0] ct_init,
  input  logic [SEL_W-1:0]       ct_sel,
  input  logic [1:0]             mode,
  output logic                   init_set,
  output logic                   init_clr
);

  init_mode_e mode_e;
  logic       term;

  assign mode_e   = init_mode_e'(mode);
  assign term     = ct_init[ct_sel];
  assign init_set = term && (mode_e == INIT_PRESET);
  assign init_clr = term && (mode_e == INIT_CLEAR);

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic cell_clk,
  input  logic rst_n,
  input  logic init_set,
  input  logic init_clr,
  input  logic t_mode,
  input  logic din,
  output logic q
);

  always_ff @(posedge cell_clk or negedge rst_n or posedge init_set or posedge init_clr) begin
    if (!rst_n)        q <= 1'b0;
    else if (init_clr) q <= 1'b0;
    else if (init_set) q <= 1'b1;
    else               q <= ff_next(q, din, t_mode);
  end

  // R5
  preset_hold_chk: assert property (@(posedge cell_clk) disable iff (!rst_n)
    init_set |-> q);

  // R5
  clear_hold_chk: assert property (@(posedge cell_clk) disable iff (!rst_n)
    init_clr |-> !q);

endmodule

// File: rtl/mcell_out_ctl.sv
module mcell_out_ctl
  import mcell_pkg::*;
#(
  parameter int NUM_OE_CT = 4,
  localparam int OE_SEL_W = $clog2(NUM_OE_CT + 2)
) (
  input  logic                 smp_clk,
  input  logic                 rst_n,
  input  logic                 q,
  input  logic                 sop_in,
  input  logic                 bypass,
  input  logic [OE_SEL_W-1:0]  oe_sel,
  input  logic [NUM_OE_CT-1:0] ct_oe,
  input  logic                 gts_n,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 mc_fb,
  output logic                 pin_fb
);

  localparam logic [OE_SEL_W-1:0] SEL_ON = OE_SEL_W'(NUM_OE_CT);

  function automatic logic local_enable(input logic [OE_SEL_W-1:0] s,
                                        input logic [NUM_OE_CT-1:0] ct);
    logic r;
    r = (s == SEL_ON);
    for (int i = 0; i < NUM_OE_CT; i++) begin
      if (s == OE_SEL_W'(i)) r = ct[i];
    end
    return r;
  endfunction

  logic cell_val;
  logic oe_local;

  assign cell_val = bypass ? sop_in : q;
  assign oe_local = local_enable(oe_sel, ct_oe);
  assign pad_oe   = oe_local & gts_n;
  assign pad_out  = cell_val;
  assign mc_fb    = cell_val;
  assign pin_fb   = pad_view(cell_val, pad_oe, pad_in);

  // R8
  gts_off_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    !gts_n |-> !pad_oe);

  // R7
  oe_off_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (oe_sel > SEL_ON) |-> !pad_oe);

  // R7
  oe_on_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    ((oe_sel == SEL_ON) && gts_n) |-> pad_oe);

  // R9
  bypass_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    bypass |-> (pad_out == sop_in));

  // R10
  pin_fb_chk: assert property (@(posedge smp_clk) disable iff (!rst_n)
    !pad_oe |-> (pin_fb == pad_in));

endmodule

// File: rtl/mcell_stage.sv
module mcell_stage #(
  parameter int NUM_CLK = 4,
  parameter int NUM_INIT_CT = 2,
  parameter int NUM_OE_CT = 4,
  localparam int CLK_SEL_W = $clog2(NUM_CLK),
  localparam int INIT_SEL_W = $clog2(NUM_INIT_CT),
  localparam int OE_SEL_W = $clog2(NUM_OE_CT + 2),
  localparam int NUM_CT = NUM_INIT_CT + NUM_OE_CT
) (
  input  logic                  rst_n,
  input  logic [NUM_CLK-1:0]    ext_clk,
  input  logic [NUM_CLK-2:0]    eqn_clk,
  input  logic                  sop_in,
  input  logic [NUM_CT-1:0]     ctrl_term,
  input  logic                  gts_n,
  input  logic                  pad_in,
  input  logic                  cfg_t_mode,
  input  logic [CLK_SEL_W-1:0]  cfg_clk_sel,
  input  logic                  cfg_clk_inv,
  input  logic [NUM_CLK-2:0]    cfg_clk_src,
  input  logic [1:0]            cfg_init_mode,
  input  logic [INIT_SEL_W-1:0] cfg_init_ct,
  input  logic [OE_SEL_W-1:0]   cfg_oe_sel,
  input  logic                  cfg_bypass,
  output logic                  pad_out,
  output logic                  pad_oe,
  output logic                  mc_fb,
  output logic                  pin_fb
);

  logic cell_clk;
  logic init_set;
  logic init_clr;
  logic cell_q;

  mcell_clk_pick #(.NUM_CLK(NUM_CLK)) u_clk (
    .ext_clk (ext_clk),
    .eqn_clk (eqn_clk),
    .src_eqn (cfg_clk_src),
    .sel     (cfg_clk_sel),
    .inv     (cfg_clk_inv),
    .cell_clk(cell_clk)
  );

  mcell_init_ctl #(.NUM_INIT_CT(NUM_INIT_CT)) u_init (
    .ct_init (ctrl_term[NUM_INIT_CT-1:0]),
    .ct_sel  (cfg_init_ct),
    .mode    (cfg_init_mode),
    .init_set(init_set),
    .init_clr(init_clr)
  );

  mcell_store u_store (
    .cell_clk(cell_clk),
    .rst_n   (rst_n),
    .init_set(init_set),
    .init_clr(init_clr),
    .t_mode  (cfg_t_mode),
    .din     (sop_in),
    .q       (cell_q)
  );

  mcell_out_ctl #(.NUM_OE_CT(NUM_OE_CT)) u_out (
    .smp_clk(ext_clk[0]),
    .rst_n  (rst_n),
    .q      (cell_q),
    .sop_in (sop_in),
    .bypass (cfg_bypass),
    .oe_sel (cfg_oe_sel),
    .ct_oe  (ctrl_term[NUM_CT-1:NUM_INIT_CT]),
    .gts_n  (gts_n),
    .pad_in (pad_in),
    .pad_out(pad_out),
    .pad_oe (pad_oe),
    .mc_fb  (mc_fb),
    .pin_fb (pin_fb)
  );

endmodule

// File: tb/tb_mcell_stage.sv
module tb_mcell_stage;

  logic       clk0 = 1'b0;
  logic [2:0] ext_hi = '0;
  logic [2:0] eqn_clk = '0;
  logic       rst_n = 1'b0;
  logic       sop_in = 1'b0;
  logic [5:0] ctrl_term = '0;
  logic       gts_n = 1'b1;
  logic       pad_in = 1'b0;
  logic       cfg_t_mode = 1'b0;
  logic [1:0] cfg_clk_sel = '0;
  logic       cfg_clk_inv = 1'b0;
  logic [2:0] cfg_clk_src = '0;
  logic [1:0] cfg_init_mode = '0;
  logic       cfg_init_ct = 1'b0;
  logic [2:0] cfg_oe_sel = 3'd4;
  logic       cfg_bypass = 1'b0;
  logic       pad_out, pad_oe, mc_fb, pin_fb;

  int errors = 0;
  int checks = 0;

  always #10 clk0 = ~clk0;  // 50 MHz

  mcell_stage dut (
    .rst_n        (rst_n),
    .ext_clk      ({ext_hi, clk0}),
    .eqn_clk      (eqn_clk),
    .sop_in       (sop_in),
    .ctrl_term    (ctrl_term),
    .gts_n        (gts_n),
    .pad_in       (pad_in),
    .cfg_t_mode   (cfg_t_mode),
    .cfg_clk_sel  (cfg_clk_sel),
    .cfg_clk_inv  (cfg_clk_inv),
    .cfg_clk_src  (cfg_clk_src),
    .cfg_init_mode(cfg_init_mode),
    .cfg_init_ct  (cfg_init_ct),
    .cfg_oe_sel   (cfg_oe_sel),
    .cfg_bypass   (cfg_bypass),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .mc_fb        (mc_fb),
    .pin_fb       (pin_fb)
  );

  // {t_mode, sop_in, expected register after the next rising clk0 edge}
  localparam int NVEC = 12;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b011, 3'b000, 3'b011,            // R1 D loads
    3'b101, 3'b110, 3'b111, 3'b101,    // R2 hold, toggle, toggle, hold
    3'b110, 3'b000, 3'b011,            // R2 toggle, R1 D loads
    3'b110, 3'b111                     // R2 toggles
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic at_hi();
    @(posedge clk0); #5;
  endtask

  task automatic at_lo();
    @(negedge clk0); #5;
  endtask

  task automatic pulse_ext(input int k);
    ext_hi[k-1] = 1'b1; #2; ext_hi[k-1] = 1'b0; #1;
  endtask

  task automatic pulse_eqn(input int k);
    eqn_clk[k-1] = 1'b1; #2; eqn_clk[k-1] = 1'b0; #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R6: reset dominates an active preset request and clock edges
    #3;
    sop_in = 1'b1; cfg_init_mode = 2'd1; ctrl_term[0] = 1'b1;
    #32;
    chk("R6 reset pad_out", pad_out, 1'b0);
    chk("R6 reset mc_fb", mc_fb, 1'b0);
    ctrl_term[0] = 1'b0; cfg_init_mode = 2'd0; sop_in = 1'b0;
    at_hi();
    rst_n = 1'b1;

    // R1/R2 vector table on rising clk0
    for (int i = 0; i < NVEC; i++) begin
      cfg_t_mode = VEC[i][2];
      sop_in     = VEC[i][1];
      at_hi();
      chk(VEC[i][2] ? "R2 toggle table" : "R1 load table", pad_out, VEC[i][0]);
      chk("R1 mc_fb table", mc_fb, VEC[i][0]);
    end

    // R3 falling edge (register holds 1, clk0 is high)
    cfg_t_mode = 1'b0; sop_in = 1'b0; cfg_clk_inv = 1'b1;
    #2 chk("R3 no capture before falling edge", pad_out, 1'b1);
    at_lo();
    chk("R3 falling edge captures", pad_out, 1'b0);
    sop_in = 1'b1;
    at_hi();
    chk("R3 rising edge ignored when inverted", pad_out, 1'b0);
    at_lo();
    chk("R3 falling edge captures again", pad_out, 1'b1);
    cfg_clk_inv = 1'b0;

    // R3 select clock 1 (pin source); clk0 edges must be ignored
    cfg_clk_sel = 2'd1; sop_in = 1'b0;
    repeat (2) @(posedge clk0);
    #5 chk("R3 unselected clock ignored", pad_out, 1'b1);
    pulse_ext(1);
    chk("R3 clock 1 captures", pad_out, 1'b0);

    // R4 clock 2 from its equation source
    cfg_clk_sel = 2'd2; cfg_clk_src[1] = 1'b1; sop_in = 1'b1;
    pulse_ext(2);
    chk("R4 pin clock ignored when equation chosen", pad_out, 1'b0);
    pulse_eqn(2);
    chk("R4 equation clock captures", pad_out, 1'b1);
    at_lo();
    cfg_clk_src[1] = 1'b0; cfg_clk_sel = 2'd0;

    // R5 preset from control term 0, asserted mid-cycle
    sop_in = 1'b0;
    at_hi();
    chk("R1 load before preset", pad_out, 1'b0);
    cfg_init_mode = 2'd1; cfg_init_ct = 1'b0;
    ctrl_term[0] = 1'b1;
    #1 chk("R5 preset without clock", pad_out, 1'b1);
    at_hi();
    chk("R5 preset overrides clock", pad_out, 1'b1);
    ctrl_term[0] = 1'b0;
    #1 chk("R5 value kept after release", pad_out, 1'b1);
    at_hi();
    chk("R1 clocking resumes after release", pad_out, 1'b0);

    // R5 clear from control term 1
    sop_in = 1'b1;
    at_hi();
    chk("R1 load before clear", pad_out, 1'b1);
    cfg_init_mode = 2'd2; cfg_init_ct = 1'b1;
    ctrl_term[0] = 1'b1;
    #1 chk("R5 unselected term ignored", pad_out, 1'b1);
    ctrl_term[1] = 1'b1;
    #1 chk("R5 clear without clock", pad_out, 1'b0);
    at_hi();
    chk("R5 clear overrides clock", pad_out, 1'b0);
    ctrl_term[1:0] = 2'b00;
    at_hi();
    chk("R1 clocking resumes after clear", pad_out, 1'b1);

    // R5 disabled modes 0 and 3
    cfg_init_mode = 2'd0; ctrl_term[1:0] = 2'b11;
    #1 chk("R5 mode 0 no clear", pad_out, 1'b1);
    sop_in = 1'b0;
    at_hi();
    chk("R5 mode 0 clock still loads", pad_out, 1'b0);
    cfg_init_mode = 2'd3;
    #1 chk("R5 mode 3 no preset", pad_out, 1'b0);
    sop_in = 1'b1;
    at_hi();
    chk("R5 mode 3 clock still loads", pad_out, 1'b1);
    cfg_init_mode = 2'd0; ctrl_term[1:0] = 2'b00;

    // R7 enable sources, two term patterns
    ctrl_term[5:2] = 4'b0101;
    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = 3'(s);
      #1 chk("R7 enable source pattern A", pad_oe, (s < 4) ? ctrl_term[2+s] : (s == 4));
    end
    ctrl_term[5:2] = 4'b1010;
    for (int s = 0; s < 4; s++) begin
      cfg_oe_sel = 3'(s);
      #1 chk("R7 enable source pattern B", pad_oe, ctrl_term[2+s]);
    end

    // R8 global tri-state
    gts_n = 1'b0; cfg_oe_sel = 3'd4;
    #1 chk("R8 gts overrides always-on", pad_oe, 1'b0);
    ctrl_term[2] = 1'b1; cfg_oe_sel = 3'd0;
    #1 chk("R8 gts overrides control term", pad_oe, 1'b0);
    gts_n = 1'b1;
    #1 chk("R8 enable returns", pad_oe, 1'b1);

    // R10 pad tap (register holds 1)
    pad_in = 1'b0;
    #1 chk("R10 pad tap shows driven value", pin_fb, 1'b1);
    cfg_oe_sel = 3'd5;
    #1 chk("R10 pad tap shows pin when disabled", pin_fb, 1'b0);
    pad_in = 1'b1;
    #1 chk("R10 pad tap follows pin", pin_fb, 1'b1);
    pad_in = 1'b0;
    #1 chk("R10 cell tap ignores enable", mc_fb, 1'b1);
    cfg_oe_sel = 3'd4; gts_n = 1'b0;
    #1 chk("R10 pad tap under gts", pin_fb, 1'b0);
    gts_n = 1'b1;

    // R9 bypass with the register frozen on idle clock 1
    at_lo();
    cfg_clk_sel = 2'd1;
    cfg_bypass = 1'b1; sop_in = 1'b0;
    #1 chk("R9 bypass pad_out", pad_out, 1'b0);
    chk("R9 bypass mc_fb", mc_fb, 1'b0);
    sop_in = 1'b1;
    #1 chk("R9 bypass follows sum", pad_out, 1'b1);
    sop_in = 1'b0; cfg_bypass = 1'b0;
    #1 chk("R9 register untouched by bypass", pad_out, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule